// File: doc/BRIEF.md
# Piecewise-Linear Gamma Correction Unit

This block is the gamma stage of a display compositor. It serves three display channels. Each channel holds a 16-segment transfer curve for red, green and blue, and one designated channel also holds an alpha curve. Each point of a curve stores a breakpoint, an intercept and a gradient. Host software programs the curves and a per-channel enable bit through a simple word-addressed write/read port.

Pixels arrive with a channel tag. For each component, the unit looks up the segment whose breakpoint lies at or below the input value. It then forms intercept plus gradient times the distance past the breakpoint, at full precision. The result is truncated to an integer and clamped to the pixel range. Corrected pixels leave two clock cycles later, with a valid flag that travels alongside them.

Channels whose enable bit is clear pass their pixels through unchanged. Alpha on any channel other than the alpha channel also passes through unchanged.

Top module: `gamma_pwl_unit`

## Requirements
- R1: After reset, every curve point i on every channel and component has breakpoint i*256, intercept i*4096 (12.4 form) and gradient 0x100 (4.8 form). All channel enables are clear, `out_valid` is 0 and `reg_rdata` is 0.
- R2: Table words sit at word address 0x2000 + ch*0x400 + comp*32 + pt*2 + w, with comp 0 = red, 1 = green, 2 = blue, 3 = alpha. Word w=0 carries the breakpoint in bits [31:20] and the intercept in bits [15:0]. Word w=1 carries the gradient in bits [11:0]. A read returns these fields with all other bits zero, one cycle after the address is presented.
- R3: The active segment is the highest-numbered point whose breakpoint is less than or equal to the input. If no breakpoint qualifies, point 0 is used with a distance of zero, so the output is point 0's intercept.
- R4: A corrected component equals floor((C*16 + G*(in - X)) / 256), where X, C and G are the raw breakpoint, intercept and gradient fields of the active point.
- R5: A corrected result above 4095 is output as 4095.
- R6: `out_valid` and the output data follow `in_valid` and the input pixel by exactly two clock cycles, for back-to-back and gapped input.
- R7: The enable register is at word address 0x1000, and bit n enables channel n. A pixel on a channel whose bit is clear leaves with all four components unchanged. The register reads back its value in bits [2:0].
- R8: The alpha curve applies only to channel 2. On channels 0 and 1, alpha passes through unchanged even when the channel is enabled.
- R9: Writes to the alpha area of channels 0 and 1 (comp 3) are ignored, and reads from that area return 0.
- R10: A pixel tagged 3, which names no channel, leaves with all components unchanged.
- R11: Each channel uses only its own curves and its own enable bit. Reprogramming or disabling one channel does not change the results on another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 14 | Word address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the address of the previous cycle |
| in_valid | input | 1 | Input pixel valid |
| in_chan | input | 2 | Display channel tag of the input pixel |
| in_r | input | 12 | Red in |
| in_g | input | 12 | Green in |
| in_b | input | 12 | Blue in |
| in_a | input | 12 | Alpha in |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 12 | Red out |
| out_g | output | 12 | Green out |
| out_b | output | 12 | Blue out |
| out_a | output | 12 | Alpha out |

## Verification
The bench builds the unit with its default parameters: three channels, sixteen points, a 12-bit pixel and a 2-bit tag. The 2-bit tag makes the unused tag 3 reachable. It also places the alpha curve on the last channel, so the ignored alpha areas of channels 0 and 1 can be written and read back.

With 12-bit pixels, a gradient near 16 on the top segment drives the result past 4095, which brings saturation within reach. Breakpoints offset from zero make the below-first-breakpoint case reachable. Inputs placed exactly on and one below a breakpoint exercise the segment boundaries.

// File: rtl/gamma_pwl_pkg.sv
`timescale 1ns/1ps
package gamma_pwl_pkg;
  // Field widths of a curve point (fixed by the register word layout)
  localparam int BRK_W     = 12;  // widest breakpoint supported
  localparam int ICPT_W    = 16;  // intercept, integer.fraction split by pixel width
  localparam int GRAD_W    = 12;  // gradient, unsigned 4.8
  localparam int GRAD_FRAC = 8;
  localparam int NUM_COMP  = 4;
  localparam int ALPHA_IDX = 3;

  typedef enum logic [1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2,
    COMP_ALPHA = 2'd3
  } comp_e;

  typedef struct packed {
    logic [BRK_W-1:0]  brk;
    logic [ICPT_W-1:0] icpt;
    logic [GRAD_W-1:0] grad;
  } pwl_pt_t;
endpackage

// File: rtl/gamma_pwl_regs.sv
`timescale 1ns/1ps
module gamma_pwl_regs
  import gamma_pwl_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int NUM_PTS   = 16,
  parameter int PIX_W     = 12,
  parameter int ADDR_W    = 14,
  parameter int ALPHA_CH  = 2,
  parameter int CTRL_ADDR = 'h1000,
  parameter int TBL_BASE  = 'h2000,
  parameter int CH_STRIDE = 'h400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NUM_CH-1:0] ch_en,
  output pwl_pt_t           tbl [NUM_CH][NUM_COMP][NUM_PTS]
);
  localparam int CHW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int PTW        = $clog2(NUM_PTS);
  localparam int PT_WORDS   = 2;
  localparam int COMP_WORDS = NUM_PTS * PT_WORDS;
  localparam int CH_WORDS   = NUM_COMP * COMP_WORDS;
  localparam int STEP       = (1 << PIX_W) / NUM_PTS;
  localparam int FRAC_C     = ICPT_W - PIX_W;

  // Identity point used at reset (R1)
  function automatic pwl_pt_t ident_pt(int p);
    pwl_pt_t v;
    v.brk  = BRK_W'(p * STEP);
    v.icpt = ICPT_W'((p * STEP) << FRAC_C);
    v.grad = GRAD_W'(1 << GRAD_FRAC);
    return v;
  endfunction

  logic [ADDR_W-1:0] rel, off;
  logic              in_tbl, slot_live, is_ctrl, word_hi;
  logic [CHW-1:0]    i_ch;
  logic [1:0]        i_cp;
  logic [PTW-1:0]    i_pt;

  // Address decode (R2), alpha area of non-alpha channels is dead (R9)
  always_comb begin
    rel     = addr - ADDR_W'(TBL_BASE);
    off     = rel % ADDR_W'(CH_STRIDE);
    in_tbl  = (addr >= ADDR_W'(TBL_BASE)) &&
              ((rel / ADDR_W'(CH_STRIDE)) < ADDR_W'(NUM_CH)) &&
              (off < ADDR_W'(CH_WORDS));
    i_ch    = CHW'(rel / ADDR_W'(CH_STRIDE));
    i_cp    = 2'(off / ADDR_W'(COMP_WORDS));
    i_pt    = PTW'(off / ADDR_W'(PT_WORDS));
    word_hi = off[0];
    slot_live = in_tbl && ((i_cp != 2'(ALPHA_IDX)) || (int'(i_ch) == ALPHA_CH));
    is_ctrl = (addr == ADDR_W'(CTRL_ADDR));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_en <= '0;
      for (int c = 0; c < NUM_CH; c++)
        for (int k = 0; k < NUM_COMP; k++)
          for (int p = 0; p < NUM_PTS; p++)
            tbl[c][k][p] <= ident_pt(p);
    end else if (wr_en) begin
      if (is_ctrl) ch_en <= wdata[NUM_CH-1:0];
      if (slot_live) begin
        if (!word_hi) begin
          tbl[i_ch][i_cp][i_pt].brk  <= BRK_W'(wdata[31 -: PIX_W]);
          tbl[i_ch][i_cp][i_pt].icpt <= wdata[ICPT_W-1:0];
        end else begin
          tbl[i_ch][i_cp][i_pt].grad <= wdata[GRAD_W-1:0];
        end
      end
    end
  end

  // Registered read path, one cycle after the address (R2)
  logic [31:0] rd_next;
  pwl_pt_t     rd_pt;
  always_comb begin
    rd_next = '0;
    rd_pt   = tbl[i_ch][i_cp][i_pt];
    if (is_ctrl) begin
      rd_next[NUM_CH-1:0] = ch_en;
    end else if (slot_live) begin
      if (!word_hi) begin
        rd_next[31 -: PIX_W]   = rd_pt.brk[PIX_W-1:0];
        rd_next[ICPT_W-1:0]    = rd_pt.icpt;
      end else begin
        rd_next[GRAD_W-1:0]    = rd_pt.grad;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;
endmodule

// File: rtl/gamma_pwl_lane.sv
`timescale 1ns/1ps
module gamma_pwl_lane
  import gamma_pwl_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int NUM_PTS  = 16,
  parameter int PIX_W    = 12,
  parameter int TAG_W    = 2,
  parameter int ALPHA_CH = 2,
  parameter bit IS_ALPHA = 1'b0
) (
  input  logic              clk,
  input  logic [TAG_W-1:0]  chan,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [PIX_W-1:0]  pix_in,
  input  pwl_pt_t           crv [NUM_CH][NUM_PTS],
  output logic [PIX_W-1:0]  pix_out
);
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int PTW   = $clog2(NUM_PTS);
  localparam int C_SH  = GRAD_FRAC - (ICPT_W - PIX_W);
  localparam int ACC_W = GRAD_W + PIX_W + 1;
  localparam int MAXV  = (1 << PIX_W) - 1;

  // Stage 1: segment search and operand selection (R3, R7, R8, R10)
  logic             byp, hit;
  logic [CHW-1:0]   ci;
  logic [PTW-1:0]   seg;
  pwl_pt_t          cur;
  logic [PIX_W-1:0] diff;

  always_comb begin
    byp  = 1'b1;
    hit  = 1'b0;
    seg  = '0;
    ci   = chan[CHW-1:0];
    cur  = crv[ci][0];
    diff = '0;
    if (chan < TAG_W'(NUM_CH)) begin
      byp = !ch_en[ci] || (IS_ALPHA && (chan != TAG_W'(ALPHA_CH)));
      for (int i = 0; i < NUM_PTS; i++) begin
        if (crv[ci][i].brk[PIX_W-1:0] <= pix_in) begin
          seg = PTW'(i);
          hit = 1'b1;
        end
      end
      cur  = crv[ci][seg];
      diff = hit ? (pix_in - cur.brk[PIX_W-1:0]) : '0;
    end
  end

  logic              s1_byp;
  logic [PIX_W-1:0]  s1_raw, s1_diff;
  logic [ICPT_W-1:0] s1_icpt;
  logic [GRAD_W-1:0] s1_grad;

  always_ff @(posedge clk) begin
    s1_byp  <= byp;
    s1_raw  <= pix_in;
    s1_diff <= diff;
    s1_icpt <= cur.icpt;
    s1_grad <= cur.grad;
  end

  // Stage 2: multiply-add, truncate, saturate (R4, R5)
  logic [ACC_W-1:0] acc, whole;
  logic [PIX_W-1:0] res;
  always_comb begin
    acc   = (ACC_W'(s1_icpt) << C_SH) + ACC_W'(s1_grad) * ACC_W'(s1_diff);
    whole = acc >> GRAD_FRAC;
    res   = (whole > ACC_W'(MAXV)) ? PIX_W'(MAXV) : whole[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    pix_out <= s1_byp ? s1_raw : res;
  end
endmodule

// File: rtl/gamma_pwl_unit.sv
`timescale 1ns/1ps
module gamma_pwl_unit
  import gamma_pwl_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int NUM_PTS   = 16,
  parameter int PIX_W     = 12,
  parameter int TAG_W     = 2,
  parameter int ADDR_W    = 14,
  parameter int ALPHA_CH  = 2,
  parameter int CTRL_ADDR = 'h1000,
  parameter int TBL_BASE  = 'h2000,
  parameter int CH_STRIDE = 'h400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_chan,
  input  logic [PIX_W-1:0]  in_r,
  input  logic [PIX_W-1:0]  in_g,
  input  logic [PIX_W-1:0]  in_b,
  input  logic [PIX_W-1:0]  in_a,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b,
  output logic [PIX_W-1:0]  out_a
);
  logic [NUM_CH-1:0] gamma_en;
  pwl_pt_t           tbl      [NUM_CH][NUM_COMP][NUM_PTS];
  pwl_pt_t           lane_crv [NUM_COMP][NUM_CH][NUM_PTS];
  logic [PIX_W-1:0]  lane_in  [NUM_COMP];
  logic [PIX_W-1:0]  lane_out [NUM_COMP];

  gamma_pwl_regs #(
    .NUM_CH(NUM_CH), .NUM_PTS(NUM_PTS), .PIX_W(PIX_W), .ADDR_W(ADDR_W),
    .ALPHA_CH(ALPHA_CH), .CTRL_ADDR(CTRL_ADDR), .TBL_BASE(TBL_BASE),
    .CH_STRIDE(CH_STRIDE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ch_en(gamma_en), .tbl(tbl)
  );

  always_comb begin
    for (int k = 0; k < NUM_COMP; k++)
      for (int c = 0; c < NUM_CH; c++)
        for (int p = 0; p < NUM_PTS; p++)
          lane_crv[k][c][p] = tbl[c][k][p];
  end

  assign lane_in[COMP_RED]   = in_r;
  assign lane_in[COMP_GREEN] = in_g;
  assign lane_in[COMP_BLUE]  = in_b;
  assign lane_in[COMP_ALPHA] = in_a;

  for (genvar k = 0; k < NUM_COMP; k++) begin : g_lane
    gamma_pwl_lane #(
      .NUM_CH(NUM_CH), .NUM_PTS(NUM_PTS), .PIX_W(PIX_W), .TAG_W(TAG_W),
      .ALPHA_CH(ALPHA_CH), .IS_ALPHA(k == ALPHA_IDX)
    ) u_lane (
      .clk(clk), .chan(in_chan), .ch_en(gamma_en), .pix_in(lane_in[k]),
      .crv(lane_crv[k]), .pix_out(lane_out[k])
    );
  end

  // Valid flag travels with the two data stages (R6)
  logic v1, v2;
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
    end
  end

  assign out_valid = v2;
  assign out_r = lane_out[COMP_RED];
  assign out_g = lane_out[COMP_GREEN];
  assign out_b = lane_out[COMP_BLUE];
  assign out_a = lane_out[COMP_ALPHA];
endmodule

// File: rtl/gamma_pwl_chk.sv
`timescale 1ns/1ps
module gamma_pwl_chk #(
  parameter int NUM_CH    = 3,
  parameter int NUM_PTS   = 16,
  parameter int PIX_W     = 12,
  parameter int TAG_W     = 2,
  parameter int ADDR_W    = 14,
  parameter int ALPHA_CH  = 2,
  parameter int TBL_BASE  = 'h2000,
  parameter int CH_STRIDE = 'h400
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [TAG_W-1:0]  in_chan,
  input logic [PIX_W-1:0]  in_r,
  input logic [PIX_W-1:0]  in_g,
  input logic [PIX_W-1:0]  in_b,
  input logic [PIX_W-1:0]  in_a,
  input logic              out_valid,
  input logic [PIX_W-1:0]  out_r,
  input logic [PIX_W-1:0]  out_g,
  input logic [PIX_W-1:0]  out_b,
  input logic [PIX_W-1:0]  out_a,
  input logic [NUM_CH-1:0] gamma_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata
);
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic pass_now;
  always_comb
    pass_now = (in_chan >= TAG_W'(NUM_CH)) ? 1'b1 : !gamma_en[in_chan[CHW-1:0]];

  logic dead_alpha;
  always_comb begin
    dead_alpha = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if (c != ALPHA_CH &&
          int'(reg_addr) >= TBL_BASE + c*CH_STRIDE + 3*NUM_PTS*2 &&
          int'(reg_addr) <  TBL_BASE + c*CH_STRIDE + 4*NUM_PTS*2)
        dead_alpha = 1'b1;
  end

  AST_TWO_CYCLE_VALID: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R6

  AST_BYPASS_UNCHANGED: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && out_valid && $past(pass_now, 2)) |->
      (out_r == $past(in_r, 2) && out_g == $past(in_g, 2) && out_b == $past(in_b, 2))); // R7

  AST_ALPHA_PASS: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && out_valid && $past(in_chan, 2) != TAG_W'(ALPHA_CH)) |->
      (out_a == $past(in_a, 2))); // R8

  AST_DEAD_ALPHA_READ: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && $past(dead_alpha)) |-> (reg_rdata == 32'd0)); // R9
endmodule

bind gamma_pwl_unit gamma_pwl_chk #(
  .NUM_CH(NUM_CH), .NUM_PTS(NUM_PTS), .PIX_W(PIX_W), .TAG_W(TAG_W),
  .ADDR_W(ADDR_W), .ALPHA_CH(ALPHA_CH), .TBL_BASE(TBL_BASE), .CH_STRIDE(CH_STRIDE)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
  .in_r(in_r), .in_g(in_g), .in_b(in_b), .in_a(in_a),
  .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b), .out_a(out_a),
  .gamma_en(gamma_en), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/test_gamma_pwl_unit.sv
`timescale 1ns/1ps
module test_gamma_pwl_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [13:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic [1:0]  in_chan = '0;
  logic [11:0] in_r = '0, in_g = '0, in_b = '0, in_a = '0;
  logic        out_valid;
  logic [11:0] out_r, out_g, out_b, out_a;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gamma_pwl_unit i_gamma_pwl_unit (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_chan(in_chan), .in_r(in_r), .in_g(in_g), .in_b(in_b), .in_a(in_a),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
    .out_a(out_a)
  );

  // Shadow of the programmed curves, built from the requirements
  int sx [3][4][16];
  int sc [3][4][16];
  int sg [3][4][16];
  bit [2:0] sen;

  task automatic shadow_identity();
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 4; k++)
        for (int p = 0; p < 16; p++) begin
          sx[c][k][p] = p * 256;
          sc[c][k][p] = p * 4096;
          sg[c][k][p] = 'h100;
        end
    sen = 3'b000;
  endtask

  // Expected component value per R3, R4, R5, R7, R8, R10
  function automatic int model(int ch, int cp, int v);
    int seg, acc, w, d;
    bit hit;
    if (ch >= 3) return v;
    if (!sen[ch]) return v;
    if (cp == 3 && ch != 2) return v;
    seg = 0;
    hit = 1'b0;
    for (int p = 0; p < 16; p++)
      if (sx[ch][cp][p] <= v) begin seg = p; hit = 1'b1; end
    d   = hit ? v - sx[ch][cp][seg] : 0;
    acc = sc[ch][cp][seg] * 16 + sg[ch][cp][seg] * d;
    w   = acc / 256;
    if (w > 4095) w = 4095;
    return w;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(int a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_addr = 14'(a);
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 14'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic int pt_addr(int ch, int cp, int p);
    return 'h2000 + ch * 'h400 + cp * 32 + p * 2;
  endfunction

  task automatic prog_point(int ch, int cp, int p, int x, int c, int g);
    reg_write(pt_addr(ch, cp, p), (32'(x) << 20) | 32'(c));
    reg_write(pt_addr(ch, cp, p) + 1, 32'(g));
    if (!(cp == 3 && ch != 2)) begin
      sx[ch][cp][p] = x;
      sc[ch][cp][p] = c;
      sg[ch][cp][p] = g;
    end
  endtask

  task automatic send_pix(int ch, int r, int g, int b, int a, string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_chan = 2'(ch);
    in_r = 12'(r); in_g = 12'(g); in_b = 12'(b); in_a = 12'(a);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(req, "out_valid", 32'(out_valid), 32'd1);
    check(req, "red",   32'(out_r), 32'(model(ch, 0, r)));
    check(req, "green", 32'(out_g), 32'(model(ch, 1, g)));
    check(req, "blue",  32'(out_b), 32'(model(ch, 2, b)));
    check(req, "alpha", 32'(out_a), 32'(model(ch, 3, a)));
  endtask

  // Stimulus table: {channel, red, green, blue, alpha}
  localparam int NV = 15;
  localparam int VEC [NV][5] = '{
    '{0,    0,   50,    0,   17},
    '{0,  255,   99, 4095, 4095},
    '{0,  256,  100, 2048,  123},
    '{0, 4095, 3100,  300,    0},
    '{0, 1700, 3099,    1, 2222},
    '{0, 3839, 4095, 3840,    1},
    '{1,  100,  200, 4095,  999},
    '{1,  500,  600,  256,   77},
    '{1,   10,   20,  300,    5},
    '{1, 3000, 3000, 3700, 3000},
    '{2,    1,    2,    3, 4095},
    '{2, 4000, 4001, 4002,  256},
    '{2,    0,    0,    0,    0},
    '{2, 2047, 2048, 2049,  255},
    '{3,   11,   22,   33,   44}
  };

  initial begin
    #1000000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    shadow_identity();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", "out_valid after reset", 32'(out_valid), 32'd0);
    check("R1", "reg_rdata after reset", reg_rdata, 32'd0);
    reg_read('h1000, rd);
    check("R1", "enables clear", rd, 32'd0);
    reg_read(pt_addr(1, 1, 5), rd);
    check("R1", "identity word0", rd, 32'h5000_5000);
    reg_read(pt_addr(1, 1, 5) + 1, rd);
    check("R2", "identity gradient word", rd, 32'h0000_0100);

    // R7: all channels disabled, pixels unchanged
    send_pix(0, 1234, 2000, 77, 4000, "R7");

    reg_write('h1000, 32'h7);
    sen = 3'b111;
    reg_read('h1000, rd);
    check("R7", "enable readback", rd, 32'h7);

    // R4: identity curve
    send_pix(0, 1000, 4095, 0, 5, "R4");

    for (int p = 0; p < 16; p++) begin
      prog_point(0, 0, p, p * 256, (p * 200) << 4, 'h80 + p * 'h40);
      prog_point(0, 1, p, p * 200 + 100, (p * 256) << 4, 'h1A0);
      prog_point(1, 2, p, p * 256, (p * 260) << 4, 'hFFF);
      prog_point(2, 3, p, p * 256, (p * 100) << 4, 'h080);
      prog_point(0, 3, p, 0, 'hFFFF, 'hFFF);
    end

    // R9: ignored alpha area reads zero
    reg_read(pt_addr(0, 3, 4), rd);
    check("R9", "ch0 alpha word0", rd, 32'd0);
    reg_read(pt_addr(1, 3, 9) + 1, rd);
    check("R9", "ch1 alpha word1", rd, 32'd0);
    // R2: programmed fields read back
    reg_read(pt_addr(2, 3, 7) + 1, rd);
    check("R2", "ch2 alpha gradient", rd, 32'h80);
    reg_read(pt_addr(0, 1, 2), rd);
    check("R2", "ch0 green word0", rd, (32'(500) << 20) | 32'(512 << 4));

    // R3 R4 R5 R8 R10: table walk
    for (int v = 0; v < NV; v++)
      send_pix(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], "R3/R4/R5/R8/R10 vector");

    // R6: back-to-back and gapped input
    @(negedge clk);
    in_valid = 1'b1; in_chan = 2'd0; in_r = 12'd256;
    @(negedge clk);
    in_valid = 1'b0; in_r = 12'd999;
    @(negedge clk);
    check("R6", "valid t0", 32'(out_valid), 32'd1);
    check("R6", "data t0", 32'(out_r), 32'(model(0, 0, 256)));
    in_valid = 1'b1; in_r = 12'd1000;
    @(negedge clk);
    check("R6", "gap", 32'(out_valid), 32'd0);
    in_valid = 1'b1; in_r = 12'd2000;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6", "valid t2", 32'(out_valid), 32'd1);
    check("R6", "data t2", 32'(out_r), 32'(model(0, 0, 1000)));
    @(negedge clk);
    check("R6", "valid t3", 32'(out_valid), 32'd1);
    check("R6", "data t3", 32'(out_r), 32'(model(0, 0, 2000)));
    @(negedge clk);
    check("R6", "drained", 32'(out_valid), 32'd0);

    // R11: disable only channel 1
    reg_write('h1000, 32'h5);
    sen = 3'b101;
    send_pix(1, 100, 200, 4095, 999, "R11 ch1 off");
    send_pix(0, 3000, 3000, 3000, 3000, "R11 ch0 on");

    // R10: unused tag
    send_pix(3, 4095, 1, 2, 3, "R10");

    // R1: reset restores identity and clears enables
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    shadow_identity();
    reg_read(pt_addr(0, 0, 3), rd);
    check("R1", "identity after re-reset", rd, 32'h3000_3000);
    reg_read('h1000, rd);
    check("R1", "enables after re-reset", rd, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule